// File: doc/BRIEF.md
# 10BASE-T Transmit Serializer and Manchester Encoder

This block is the digital transmit path of a 10 Mb/s twisted-pair PHY. A MAC-side interface presents a transmit enable and a 4-bit data nibble. The block takes one nibble every eight clock cycles and shifts it out least significant bit first. Each bit is Manchester-encoded into two half-cells, and the result drives a single digital line output. The block runs from one 20 MHz clock. One clock cycle is half a bit cell, so the serial rate is 10 Mb/s and the nibble rate is 2.5 MHz. A one-cycle strobe tells the sender in which cycle the nibble is taken.

When no frame is being sent, the line rests at 0. An idle timer restarts every time the transmit enable is seen high. After a full idle period with no enable, the block drives one link integrity pulse. It repeats the pulse once per idle period for as long as the transmitter stays quiet. The default timing is a 12 ms period and a 100 ns pulse at 20 MHz.

A digital loopback control sends the encoded stream, link pulses included, to a dedicated loopback output and holds the line at 0. The loopback takes effect only while a separate MII-level loopback control is clear. If both controls are set, the stream stays on the line and the loopback output stays at 0.

Top module: `tenbt_tx_top`

## Requirements
- R1: While rst_n is low, line_out and lpbk_out are 0; this holds even if reset is asserted in the middle of a frame.
- R2: nib_take is high for exactly one cycle out of every eight. tx_en and txd are sampled at the rising edge that ends a cycle with nib_take high.
- R3: A sampled nibble is sent least significant bit first. Its first half-cell appears on the output one cycle after the sampling edge, and the eight half-cells follow on consecutive cycles.
- R4: A data bit of 1 is sent as 0 in its first half-cell and 1 in its second half-cell.
- R5: A data bit of 0 is sent as 1 in its first half-cell and 0 in its second half-cell.
- R6: When no frame is in flight and no link pulse is active, line_out is 0.
- R7: After IDLE_CYCLES cycles with tx_en low and no frame in flight, a link pulse of PULSE_CYCLES cycles is driven high. Pulses repeat with a start-to-start spacing of IDLE_CYCLES cycles while idle continues.
- R8: Any cycle with tx_en high restarts the idle timer, even a single cycle that starts no frame. After the last such cycle, the next pulse appears on the output IDLE_CYCLES+2 clock edges later, counting the edge that sampled tx_en as the first. No link pulse is emitted while tx_en is high or a frame is in flight.
- R9: With dig_lpbk=1 and mii_lpbk=0, line_out is 0 and lpbk_out carries the encoded stream, link pulses included.
- R10: With mii_lpbk=1, dig_lpbk has no effect: line_out carries the stream and lpbk_out is 0. lpbk_out is also 0 whenever dig_lpbk is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 20 MHz clock, one cycle per half bit cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable from the MAC side |
| txd | input | NIB_W | Transmit nibble |
| dig_lpbk | input | 1 | Digital loopback request |
| mii_lpbk | input | 1 | MII-level loopback control; when set, it blocks the digital loopback |
| nib_take | output | 1 | High in the cycle before the edge that samples tx_en and txd |
| line_out | output | 1 | Encoded line bit toward the analog driver |
| lpbk_out | output | 1 | Encoded stream routed toward the receive path |

## Verification
The hardest condition to reach from the ports is a restart of the idle timer by a tx_en pulse that starts no frame. A pulse of this kind is only possible when tx_en is high in a cycle where nib_take is low. The bench watches nib_take and raises tx_en for exactly one such cycle, halfway through an idle gap. It then counts clock edges to the next pulse and compares the count with the restarted period. Link pulses in loopback are reached by holding dig_lpbk through a whole idle period, and a mid-frame reset is reached by asserting rst_n a few cycles after the nibble is sampled.

// File: rtl/tenbt_tx_pkg.sv
package tenbt_tx_pkg;

    // Registered outputs of the line stage
    typedef struct packed {
        logic line;
        logic lb;
    } out_st_t;

    // Half-cell value of a Manchester bit: first half inverted, second half true
    function automatic logic mcode(input logic data_bit, input logic second_half);
        return data_bit ~^ second_half;
    endfunction

endpackage

// File: rtl/tenbt_tx_ser.sv
module tenbt_tx_ser #(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic [NIB_W-1:0] txd,
    output logic             nib_take,
    output logic             frame_on,
    output logic             enc
);
    localparam int PH_N = 2 * NIB_W;
    localparam int PH_W = $clog2(PH_N);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PH_N - 1);

    typedef struct packed {
        logic [PH_W-1:0]  ph;
        logic [NIB_W-1:0] nib;
        logic             act;
    } ser_st_t;

    ser_st_t st_d, st_q;
    logic    cur_bit;

    always_comb begin
        st_d = st_q;
        if (st_q.ph == PH_LAST) begin
            st_d.ph  = '0;
            st_d.nib = txd;
            st_d.act = tx_en;
        end else begin
            st_d.ph = st_q.ph + 1'b1;
        end
        cur_bit  = st_q.nib[st_q.ph[PH_W-1:1]];
        enc      = tenbt_tx_pkg::mcode(cur_bit, st_q.ph[0]);
        nib_take = (st_q.ph == PH_LAST);
        frame_on = st_q.act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Strobe never lasts two cycles
    assert_take_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        nib_take |=> !nib_take);

    // Second half-cell is the complement of the first (R4, R5)
    assert_half_invert_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && st_q.ph[0]) |-> (enc != $past(enc)));

endmodule

// File: rtl/tenbt_tx_link.sv
module tenbt_tx_link #(
    parameter int IDLE_CYCLES  = 240000,
    parameter int PULSE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    output logic pulse_on
);
    localparam int CNT_W = $clog2(IDLE_CYCLES);
    localparam int PW_W  = $clog2(PULSE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_CYCLES - 1);
    localparam logic [PW_W-1:0]  PW_LOAD  = PW_W'(PULSE_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PW_W-1:0]  pw;
    } link_st_t;

    link_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (busy) begin
            st_d.cnt = '0;
            st_d.pw  = '0;
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.cnt = '0;
            st_d.pw  = PW_LOAD;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.pw != '0) st_d.pw = st_q.pw - 1'b1;
        end
        pulse_on = (st_q.pw != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_no_pulse_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !pulse_on);

    assert_pulse_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_on && !busy && (st_q.pw > PW_W'(1))) |=> pulse_on);

endmodule

// File: rtl/tenbt_tx_top.sv
module tenbt_tx_top #(
    parameter int NIB_W        = 4,
    parameter int IDLE_CYCLES  = 240000,
    parameter int PULSE_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic [NIB_W-1:0] txd,
    input  logic             dig_lpbk,
    input  logic             mii_lpbk,
    output logic             nib_take,
    output logic             line_out,
    output logic             lpbk_out
);
    import tenbt_tx_pkg::*;

    logic    frame_on, enc, pulse_on, stream, lb_en;
    out_st_t out_d, out_q;

    tenbt_tx_ser #(.NIB_W(NIB_W)) ser_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .txd      (txd),
        .nib_take (nib_take),
        .frame_on (frame_on),
        .enc      (enc)
    );

    tenbt_tx_link #(
        .IDLE_CYCLES  (IDLE_CYCLES),
        .PULSE_CYCLES (PULSE_CYCLES)
    ) link_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (tx_en | frame_on),
        .pulse_on (pulse_on)
    );

    always_comb begin
        stream    = frame_on ? enc : pulse_on;
        lb_en     = dig_lpbk & ~mii_lpbk;
        out_d.line = lb_en ? 1'b0 : stream;
        out_d.lb   = lb_en ? stream : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign line_out = out_q.line;
    assign lpbk_out = out_q.lb;

    assert_line_muted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_lpbk && !mii_lpbk) |=> !line_out);

    assert_lpbk_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(dig_lpbk && !mii_lpbk) |=> !lpbk_out);

    assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_on && !pulse_on) |=> !line_out);

endmodule

// File: tb/tenbt_tx_top_tb_top.sv
module tenbt_tx_top_tb_top;
    localparam int IDLE = 40;
    localparam int PW   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic [3:0] txd = '0;
    logic       dig_lpbk = 1'b0;
    logic       mii_lpbk = 1'b0;
    logic       nib_take, line_out, lpbk_out;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    tenbt_tx_top #(.NIB_W(4), .IDLE_CYCLES(IDLE), .PULSE_CYCLES(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .txd(txd),
        .dig_lpbk(dig_lpbk), .mii_lpbk(mii_lpbk),
        .nib_take(nib_take), .line_out(line_out), .lpbk_out(lpbk_out)
    );

    // {txd, dig, mii, line half-cells, lpbk half-cells}; bit k = k-th half-cell
    localparam int NV = 8;
    localparam logic [21:0] VEC [NV] = '{
        {4'hA, 1'b0, 1'b0, 8'h99, 8'h00},
        {4'h0, 1'b0, 1'b0, 8'h55, 8'h00},
        {4'hF, 1'b0, 1'b0, 8'hAA, 8'h00},
        {4'h1, 1'b0, 1'b0, 8'h56, 8'h00},
        {4'h8, 1'b1, 1'b0, 8'h00, 8'h95},
        {4'hA, 1'b1, 1'b1, 8'h99, 8'h00},
        {4'hF, 1'b1, 1'b0, 8'h00, 8'hAA},
        {4'h0, 1'b0, 1'b1, 8'h55, 8'h00}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_take();
        @(negedge clk);
        while (!nib_take) @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] got_l, got_b;
        int n, w, lo;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 line in reset", line_out, 0);
        chk("R1 lpbk in reset", lpbk_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 line after reset", line_out, 0);

        // R2: strobe spacing
        wait_take();
        n = 0;
        @(negedge clk);
        n++;
        while (!nib_take) begin @(negedge clk); n++; end
        chk("R2 nib_take spacing", n, 8);

        // R3 R4 R5 R9 R10: vector table
        for (int v = 0; v < NV; v++) begin
            wait_take();
            tx_en    = 1'b1;
            txd      = VEC[v][21:18];
            dig_lpbk = VEC[v][17];
            mii_lpbk = VEC[v][16];
            @(posedge clk);
            for (int k = 0; k < 8; k++) begin
                @(posedge clk);
                @(negedge clk);
                got_l[k] = line_out;
                got_b[k] = lpbk_out;
            end
            chk($sformatf("R3 R4 R5 R9 R10 line vec%0d", v), int'(got_l), int'(VEC[v][15:8]));
            chk($sformatf("R3 R4 R5 R9 R10 lpbk vec%0d", v), int'(got_b), int'(VEC[v][7:0]));
        end

        // R6 R7: idle, link pulses
        wait_take();
        tx_en = 1'b0; dig_lpbk = 1'b0; mii_lpbk = 1'b0; txd = '0;
        repeat (10) @(negedge clk);
        lo = 0;
        while (!line_out && lo < 3 * IDLE) begin @(negedge clk); lo++; end
        w = 0;
        while (line_out && w < 3 * IDLE) begin @(negedge clk); w++; end
        chk("R7 pulse width", w, PW);
        lo = 0;
        while (!line_out && lo < 3 * IDLE) begin @(negedge clk); lo++; end
        chk("R6 R7 low gap between pulses", lo, IDLE - PW);
        w = 0;
        while (line_out && w < 3 * IDLE) begin @(negedge clk); w++; end
        chk("R7 second pulse width", w, PW);

        // R8: single-cycle tx_en away from the sampling edge restarts timer
        repeat (IDLE / 2) @(negedge clk);
        if (nib_take) @(negedge clk);
        tx_en = 1'b1;
        n = 0;
        @(posedge clk);
        n++;
        @(negedge clk);
        tx_en = 1'b0;
        while (!line_out && n < 3 * IDLE) begin @(posedge clk); n++; @(negedge clk); end
        chk("R8 timer restart delay", n, IDLE + 2);

        // R9: pulses go to loopback output, line muted
        dig_lpbk = 1'b1;
        got_l = '0;
        w = 0;
        for (int c = 0; c < 2 * IDLE; c++) begin
            @(negedge clk);
            if (line_out) got_l[0] = 1'b1;
            if (lpbk_out) w++;
        end
        chk("R9 line muted in loopback", got_l[0], 0);
        chk("R9 pulse on lpbk_out", (w >= PW) ? 1 : 0, 1);
        dig_lpbk = 1'b0;

        // R1: reset in mid-frame
        wait_take();
        tx_en = 1'b1; txd = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 line cleared mid-frame", line_out, 0);
        repeat (2) @(negedge clk);
        chk("R1 line held in reset", line_out, 0);
        tx_en = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        summary();
        $finish;
    end
endmodule